// File: doc/BRIEF.md
# Pointer Bounds Check Unit

This unit keeps a small file of pointer bounds for a processor pipeline and answers bounds questions about addresses in a single cycle. Each entry holds a lower limit and an upper limit. The upper limit is stored bit-inverted, so a freshly reset entry (all zeros) permits every address. A pipeline issues one command per cycle. The command either builds an entry from a base address and a byte count, or tests an address against the lower or the upper limit of an entry.

A failing test raises a one-cycle bound-range-exceeded pulse. It also records the offending address and a reason code in a status register, which software reads and clears through a small register port. That port also reaches two enforcement configuration registers. One governs user-privilege commands and the other governs supervisor-privilege commands; the privilege bit sent with each command picks which one applies.

The exception pulse comes from a two-state machine. `ST_IDLE` is the quiet state and `ST_FAULT` is the state that drives the pulse. `ST_IDLE -> ST_FAULT` is taken on a clock edge where an enforced test fails. `ST_FAULT -> ST_FAULT` is taken when the next command also fails. `ST_FAULT -> ST_IDLE` and `ST_IDLE -> ST_IDLE` are taken on every other edge.

Top module: `bounds_check_unit`

## Requirements
- R1: After reset every entry reads back lower limit 0 and stored upper limit 0, `bre_exc` is low, both status fields read 0, and both configuration registers read 1.
- R2: Command encoding `cmd_op`: 00 none, 01 build, 10 lower test, 11 upper test. A build sets the entry's lower limit to `cmd_addr` and its stored upper limit to the inversion of (`cmd_addr` + `cmd_size` - 1) taken modulo 2^AW. The result is visible on the readback port after the clock edge.
- R3: A build with `cmd_size` of zero marks the entry empty. Every later test against an empty entry fails until the entry is built again with a nonzero size.
- R4: A lower test fails exactly when `cmd_addr` is below the lower limit, compared as unsigned numbers.
- R5: An upper test fails exactly when `cmd_addr` is above the inverted stored upper limit, compared as unsigned numbers.
- R6: Each failing enforced test drives `bre_exc` high for exactly the one cycle after its clock edge. Back-to-back failures keep it high once per command, and it falls in the cycle after the last one.
- R7: On a failure the status address field captures `cmd_addr` and the status code field captures 01 for a lower failure or 10 for an upper failure.
- R8: The status fields hold their value until a register-port write. Writing zero clears a field. A failure in the same cycle as a status write takes precedence.
- R9: Bit 0 of a configuration register enables enforcement. `cmd_priv` = 0 selects the user register and 1 selects the supervisor register. A test under a cleared enable never raises `bre_exc` and leaves the status unchanged.
- R10: Register map on `reg_sel`: 0 user configuration, 1 supervisor configuration, 2 status address, 3 status code. Configuration registers keep only bit 0, and all other read bits are 0.
- R11: A build command never raises `bre_exc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command kind (see R2) |
| cmd_idx | input | IW | Target entry |
| cmd_priv | input | 1 | 0 user, 1 supervisor |
| cmd_addr | input | AW | Base address for a build, or the address under test |
| cmd_size | input | AW | Byte count for a build |
| reg_wr | input | 1 | Register-port write strobe |
| reg_sel | input | 2 | Register-port select (see R10) |
| reg_wdata | input | AW | Register-port write data |
| reg_rdata | output | AW | Register-port read data (combinational) |
| bnd_sel | input | IW | Entry chosen for readback |
| bnd_lb | output | AW | Lower limit of the chosen entry |
| bnd_ub_stored | output | AW | Stored (inverted) upper limit of the chosen entry |
| bre_exc | output | 1 | Bound-range-exceeded pulse |

## Verification
The bench builds the unit with AW = 8 and NB = 4. That makes the address space small enough to sweep every one of the 256 addresses through both test kinds on every entry. Each entry is built with a distinct base and size, including one range that ends exactly at the top of the space and one whose end wraps past it, so both unsigned comparisons and the modulo arithmetic of the build are covered at their edges. The same narrow width exposes the empty-range case at base 0, where the inverted limit alone would permit everything. It also lets the bench check privilege selection, status precedence and back-to-back pulses.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_MAKE = 2'b01,
        OP_CHKL = 2'b10,
        OP_CHKU = 2'b11
    } bcu_op_e;

    typedef enum logic [1:0] {
        SEL_CFG_USER  = 2'd0,
        SEL_CFG_SUP   = 2'd1,
        SEL_STAT_ADDR = 2'd2,
        SEL_STAT_CODE = 2'd3
    } bcu_sel_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FAULT = 1'b1
    } exc_state_e;

    localparam logic [1:0] CODE_LOWER = 2'b01;
    localparam logic [1:0] CODE_UPPER = 2'b10;

endpackage

// File: rtl/bcu_bound_file.sv
module bcu_bound_file #(
    parameter int AW = 64,
    parameter int NB = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_lb,
    input  logic [AW-1:0] wr_ub,
    input  logic          wr_empty,
    input  logic [IW-1:0] a_idx,
    output logic [AW-1:0] a_lb,
    output logic [AW-1:0] a_ub,
    output logic          a_empty,
    input  logic [IW-1:0] b_idx,
    output logic [AW-1:0] b_lb,
    output logic [AW-1:0] b_ub
);

    logic [AW-1:0] lb_q    [NB];
    logic [AW-1:0] ub_q    [NB];
    logic          empty_q [NB];

    for (genvar g = 0; g < NB; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lb_q[g]    <= '0;
                ub_q[g]    <= '0;
                empty_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                lb_q[g]    <= wr_lb;
                ub_q[g]    <= wr_ub;
                empty_q[g] <= wr_empty;
            end
        end
    end

    assign a_lb    = lb_q[a_idx];
    assign a_ub    = ub_q[a_idx];
    assign a_empty = empty_q[a_idx];
    assign b_lb    = lb_q[b_idx];
    assign b_ub    = ub_q[b_idx];

endmodule

// File: rtl/bcu_datapath.sv
module bcu_datapath
    import bcu_pkg::*;
#(
    parameter int AW = 64
) (
    input  bcu_op_e       op,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] size,
    input  logic [AW-1:0] ent_lb,
    input  logic [AW-1:0] ent_ub_stored,
    input  logic          ent_empty,
    output logic [AW-1:0] mk_lb,
    output logic [AW-1:0] mk_ub_stored,
    output logic          mk_empty,
    output logic          fail,
    output logic [1:0]    fail_code
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] ub_true;
    logic [AW-1:0] last_byte;

    assign last_byte    = addr + size - ONE;
    assign mk_lb        = addr;
    assign mk_ub_stored = ~last_byte;
    assign mk_empty     = (size == '0);
    assign ub_true      = ~ent_ub_stored;

    always_comb begin
        fail      = 1'b0;
        fail_code = 2'b00;
        unique case (op)
            OP_CHKL: begin
                fail      = ent_empty || (addr < ent_lb);
                fail_code = CODE_LOWER;
            end
            OP_CHKU: begin
                fail      = ent_empty || (addr > ub_true);
                fail_code = CODE_UPPER;
            end
            OP_NONE, OP_MAKE: begin
                fail      = 1'b0;
                fail_code = 2'b00;
            end
        endcase
    end

endmodule

// File: rtl/bcu_status.sv
module bcu_status
    import bcu_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_priv,
    input  logic          fault,
    input  logic [AW-1:0] fault_addr,
    input  logic [1:0]    fault_code,
    input  logic          reg_wr,
    input  bcu_sel_e      reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          enforce,
    output logic [AW-1:0] stat_addr,
    output logic [1:0]    stat_code,
    output logic          bre_exc
);

    exc_state_e    state_q, state_d;
    logic          cfg_user_q, cfg_sup_q;
    logic [AW-1:0] stat_addr_q;
    logic [1:0]    stat_code_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state: every failing enforced test (re)enters ST_FAULT
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = fault ? ST_FAULT : ST_IDLE;
            ST_FAULT: state_d = fault ? ST_FAULT : ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:  bre_exc = 1'b0;
            ST_FAULT: bre_exc = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_user_q  <= 1'b1;
            cfg_sup_q   <= 1'b1;
            stat_addr_q <= '0;
            stat_code_q <= 2'b00;
        end else begin
            if (reg_wr && reg_sel == SEL_CFG_USER) cfg_user_q <= reg_wdata[0];
            if (reg_wr && reg_sel == SEL_CFG_SUP)  cfg_sup_q  <= reg_wdata[0];
            if (fault) begin
                stat_addr_q <= fault_addr;
                stat_code_q <= fault_code;
            end else if (reg_wr) begin
                if (reg_sel == SEL_STAT_ADDR) stat_addr_q <= reg_wdata;
                if (reg_sel == SEL_STAT_CODE) stat_code_q <= reg_wdata[1:0];
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CFG_USER:  reg_rdata = {{(AW-1){1'b0}}, cfg_user_q};
            SEL_CFG_SUP:   reg_rdata = {{(AW-1){1'b0}}, cfg_sup_q};
            SEL_STAT_ADDR: reg_rdata = stat_addr_q;
            SEL_STAT_CODE: reg_rdata = {{(AW-2){1'b0}}, stat_code_q};
        endcase
    end

    assign enforce   = cmd_priv ? cfg_sup_q : cfg_user_q;
    assign stat_addr = stat_addr_q;
    assign stat_code = stat_code_q;

endmodule

// File: rtl/bounds_check_unit.sv
module bounds_check_unit
    import bcu_pkg::*;
#(
    parameter int AW = 64,
    parameter int NB = 4,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [IW-1:0] cmd_idx,
    input  logic          cmd_priv,
    input  logic [AW-1:0] cmd_addr,
    input  logic [AW-1:0] cmd_size,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic [IW-1:0] bnd_sel,
    output logic [AW-1:0] bnd_lb,
    output logic [AW-1:0] bnd_ub_stored,
    output logic          bre_exc
);

    bcu_op_e       op;
    logic [AW-1:0] ent_lb, ent_ub;
    logic          ent_empty;
    logic [AW-1:0] mk_lb, mk_ub;
    logic          mk_empty;
    logic          fail, enforce, fault, make_en;
    logic [1:0]    fail_code;
    logic [AW-1:0] stat_addr;
    logic [1:0]    stat_code;

    assign op      = bcu_op_e'(cmd_op);
    assign make_en = cmd_valid && (op == OP_MAKE);
    assign fault   = cmd_valid && enforce && fail;

    bcu_bound_file #(.AW(AW), .NB(NB), .IW(IW)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (make_en),
        .wr_idx   (cmd_idx),
        .wr_lb    (mk_lb),
        .wr_ub    (mk_ub),
        .wr_empty (mk_empty),
        .a_idx    (cmd_idx),
        .a_lb     (ent_lb),
        .a_ub     (ent_ub),
        .a_empty  (ent_empty),
        .b_idx    (bnd_sel),
        .b_lb     (bnd_lb),
        .b_ub     (bnd_ub_stored)
    );

    bcu_datapath #(.AW(AW)) u_dp (
        .op            (op),
        .addr          (cmd_addr),
        .size          (cmd_size),
        .ent_lb        (ent_lb),
        .ent_ub_stored (ent_ub),
        .ent_empty     (ent_empty),
        .mk_lb         (mk_lb),
        .mk_ub_stored  (mk_ub),
        .mk_empty      (mk_empty),
        .fail          (fail),
        .fail_code     (fail_code)
    );

    bcu_status #(.AW(AW)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_priv   (cmd_priv),
        .fault      (fault),
        .fault_addr (cmd_addr),
        .fault_code (fail_code),
        .reg_wr     (reg_wr),
        .reg_sel    (bcu_sel_e'(reg_sel)),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .enforce    (enforce),
        .stat_addr  (stat_addr),
        .stat_code  (stat_code),
        .bre_exc    (bre_exc)
    );

endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic          reg_wr,
    input logic          enforce,
    input logic          bre_exc,
    input logic [AW-1:0] stat_addr,
    input logic [1:0]    stat_code
);

    AST_EXC_FROM_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        bre_exc |-> $past(cmd_valid && cmd_op[1])); // R6

    AST_MAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b01) |=> !bre_exc); // R11

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> (bre_exc || $stable(stat_code))); // R8

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> (bre_exc || $stable(stat_addr))); // R8

    AST_EXC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        bre_exc |-> (stat_code == 2'b01 || stat_code == 2'b10)); // R7

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !enforce) |=> !bre_exc); // R9

endmodule

bind bounds_check_unit bcu_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .reg_wr    (reg_wr),
    .enforce   (enforce),
    .bre_exc   (bre_exc),
    .stat_addr (stat_addr),
    .stat_code (stat_code)
);

// File: tb/bounds_check_unit_bench.sv
module bounds_check_unit_bench;

    localparam int AW = 8;
    localparam int NB = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [IW-1:0] cmd_idx = '0;
    logic          cmd_priv = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [AW-1:0] cmd_size = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic [IW-1:0] bnd_sel = '0;
    logic [AW-1:0] bnd_lb, bnd_ub_stored;
    logic          bre_exc;

    int n_vec = 0;
    int n_bad = 0;

    // bench model
    logic [AW-1:0] m_lb [NB];
    logic [AW-1:0] m_ub [NB];
    bit            m_empty [NB];
    bit            m_cfg [2];
    logic [AW-1:0] m_saddr;
    logic [1:0]    m_scode;

    always #4 clk = ~clk;

    bounds_check_unit #(.AW(AW), .NB(NB)) u_bounds_check_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_priv(cmd_priv), .cmd_addr(cmd_addr),
        .cmd_size(cmd_size), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bnd_sel(bnd_sel),
        .bnd_lb(bnd_lb), .bnd_ub_stored(bnd_ub_stored), .bre_exc(bre_exc)
    );

    task automatic check(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [AW-1:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [AW-1:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(posedge clk);
        #1 reg_wr = 1'b0;
        if (sel == 2'd0) m_cfg[0] = val[0];
        if (sel == 2'd1) m_cfg[1] = val[0];
        if (sel == 2'd2) m_saddr = val;
        if (sel == 2'd3) m_scode = val[1:0];
    endtask

    task automatic issue(input logic [1:0] op, input int idx, input bit priv,
                         input logic [AW-1:0] a, input logic [AW-1:0] sz,
                         output logic exc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = IW'(idx);
        cmd_priv = priv; cmd_addr = a; cmd_size = sz;
        @(posedge clk);
        #1 exc = bre_exc;
        cmd_valid = 1'b0;
    endtask

    task automatic build(input int idx, input logic [AW-1:0] base, input logic [AW-1:0] sz);
        logic e;
        issue(2'b01, idx, 1'b0, base, sz, e);
        check("R11 build no exception", AW'(e), '0);
        m_lb[idx]    = base;
        m_ub[idx]    = base + sz - 8'd1;
        m_empty[idx] = (sz == '0);
        bnd_sel = IW'(idx);
        #1;
        check("R2 lower limit readback", bnd_lb, base);
        check("R2 stored upper readback", bnd_ub_stored, ~m_ub[idx]);
    endtask

    function automatic bit exp_fault(int idx, bit upper, logic [AW-1:0] a, bit priv);
        if (!m_cfg[priv]) return 1'b0;
        if (m_empty[idx]) return 1'b1;
        return upper ? (a > m_ub[idx]) : (a < m_lb[idx]);
    endfunction

    task automatic test_one(string req, int idx, bit upper, logic [AW-1:0] a, bit priv);
        logic e;
        logic [AW-1:0] v;
        bit f;
        f = exp_fault(idx, upper, a, priv);
        issue(upper ? 2'b11 : 2'b10, idx, priv, a, '0, e);
        check({req, " exception"}, AW'(e), AW'(f));
        if (f) begin
            m_saddr = a;
            m_scode = upper ? 2'b10 : 2'b01;
        end
        reg_read(2'd2, v); check("R7 status address", v, m_saddr);
        reg_read(2'd3, v); check("R7 status code", v, AW'(m_scode));
    endtask

    task automatic sweep(int idx);
        for (int a = 0; a < 256; a++) begin
            test_one("R4 lower test", idx, 1'b0, AW'(a), a[0]);
            test_one("R5 upper test", idx, 1'b1, AW'(a), a[1]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired before completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] v;
        logic e;
        for (int i = 0; i < NB; i++) begin
            m_lb[i] = '0; m_ub[i] = '1; m_empty[i] = 1'b0;
        end
        m_cfg[0] = 1'b1; m_cfg[1] = 1'b1;
        m_saddr = '0; m_scode = 2'b00;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < NB; i++) begin
            bnd_sel = IW'(i);
            #1;
            check("R1 reset lower limit", bnd_lb, '0);
            check("R1 reset stored upper", bnd_ub_stored, '0);
        end
        check("R1 reset exception", AW'(bre_exc), '0);
        reg_read(2'd0, v); check("R1 reset user config", v, 8'd1);
        reg_read(2'd1, v); check("R1 reset supervisor config", v, 8'd1);
        reg_read(2'd2, v); check("R1 reset status address", v, '0);
        reg_read(2'd3, v); check("R1 reset status code", v, '0);

        // full-space entry after reset: nothing fails
        sweep(0);

        // R2 builds, including top-of-space and wrapped ranges
        build(0, 8'd16, 8'd32);
        build(1, 8'd200, 8'd56);
        build(2, 8'd100, 8'd1);
        build(3, 8'd250, 8'd10);
        for (int i = 0; i < NB; i++) sweep(i);

        // R3 empty range at base 0 (inverted limit alone would allow all)
        build(1, 8'd0, 8'd0);
        for (int a = 0; a < 256; a += 17) begin
            test_one("R3 empty lower", 1, 1'b0, AW'(a), 1'b0);
            test_one("R3 empty upper", 1, 1'b1, AW'(a), 1'b1);
        end
        build(1, 8'd0, 8'd8);
        test_one("R3 rebuilt entry passes", 1, 1'b1, 8'd7, 1'b0);

        // R8 clear by writing zero, software write, precedence
        reg_write(2'd2, 8'd0); reg_read(2'd2, v); check("R8 clear address", v, '0);
        reg_write(2'd3, 8'd0); reg_read(2'd3, v); check("R8 clear code", v, '0);
        reg_write(2'd2, 8'h5A); reg_read(2'd2, v); check("R8 software write", v, 8'h5A);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b10; cmd_idx = 2'd0; cmd_priv = 1'b0;
        cmd_addr = 8'd3; reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 8'hC3;
        @(posedge clk);
        #1 cmd_valid = 1'b0; reg_wr = 1'b0;
        m_saddr = 8'd3; m_scode = 2'b01;
        reg_read(2'd2, v); check("R8 fault beats write", v, 8'd3);

        // R9 / R10 privilege-selected enforcement
        reg_write(2'd0, 8'hFE);
        reg_read(2'd0, v); check("R10 config keeps bit 0 only", v, 8'd0);
        reg_read(2'd1, v); check("R10 supervisor config untouched", v, 8'd1);
        test_one("R9 user disabled", 0, 1'b1, 8'd200, 1'b0);
        test_one("R9 supervisor enforced", 0, 1'b1, 8'd201, 1'b1);
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, v); check("R10 config reads one", v, 8'd1);
        reg_write(2'd1, 8'h00);
        test_one("R9 supervisor disabled", 0, 1'b0, 8'd1, 1'b1);
        test_one("R9 user enforced", 0, 1'b0, 8'd2, 1'b0);
        reg_write(2'd1, 8'h01);

        // R6 back-to-back pulses then fall
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b11; cmd_idx = 2'd2; cmd_priv = 1'b0; cmd_addr = 8'd150;
        @(posedge clk);
        #1 check("R6 first pulse", AW'(bre_exc), 8'd1);
        @(negedge clk) cmd_addr = 8'd151;
        @(posedge clk);
        #1 check("R6 second pulse", AW'(bre_exc), 8'd1);
        cmd_valid = 1'b0;
        reg_read(2'd2, v); check("R7 latest fault address", v, 8'd151);
        @(posedge clk);
        #1 check("R6 pulse ends", AW'(bre_exc), 8'd0);
        issue(2'b00, 0, 1'b0, 8'd0, 8'd0, e);
        check("R6 no-op no pulse", AW'(e), 8'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule